// File: doc/BRIEF.md
# TLB Control Register with Replacement Counter

This block is the control register that sits beside a unified translation buffer of 64 entries and a small instruction translation buffer. It holds a 6-bit replacement pointer that names the unified entry a software load will overwrite next. It also holds a wrap boundary for that pointer, a store-queue privilege bit and a virtual-memory mode bit. Writing the register with a one-shot invalidate bit set clears every valid bit in both buffers. The two valid arrays live in this block; tags and data do not.

The pointer steps once for each unified-buffer access. It wraps to zero when it meets a nonzero boundary, or after 6'h3F. When software writes a pointer value above the boundary, the pointer climbs to 6'h3F before it wraps. A load strobe marks the entry under the pointer valid and does not move the pointer. A store-queue access made in user mode raises an address-error flag when the privilege bit is set. A write that flips the mode bit without also invalidating sets a sticky warning.

Top module: `tlb_ctrl_reg`

## Requirements
- R1: After reset the register reads 0, the pointer is 0, both valid arrays are all zero and the warning flag is 0.
- R2: Field layout: boundary at bits 23:18, pointer at 15:10, store-queue privilege bit at 9, mode bit at 8, invalidate at bit 2. Bits 31:24, 17:16 and 7:3 read 0 and ignore writes, and bit 2 always reads 0.
- R3: An access strobe that finds the pointer not at a nonzero boundary advances it by one on the next clock.
- R4: With a nonzero boundary, an access made while the pointer equals the boundary sets the pointer to 0. With a zero boundary, the pointer wraps from 6'h3F to 0.
- R5: A pointer written above the boundary keeps stepping past the boundary up to 6'h3F, then goes to 0.
- R6: A load strobe does not move the pointer. It sets the unified valid bit at the current pointer value.
- R7: A register write in the same cycle as an access strobe loads the written pointer, and the increment is dropped.
- R8: A write with bit 2 set clears all unified and instruction valid bits on the next clock. This wins over any fill made in the same cycle.
- R9: sq_err_o is 1 exactly when sq_access_i and user_i are high and the privilege bit is 1. The flag is combinational.
- R10: single_vm_o follows the stored mode bit: 1 means single virtual memory mode.
- R11: A write that changes the mode bit while bit 2 is 0 sets mode_warn_o. Only reset clears it. A mode change that comes with invalidate does not set it.
- R12: itlb_fill_i sets the instruction valid bit selected by itlb_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| tlb_access_i | input | 1 | Unified-buffer access; steps the pointer |
| tlb_load_i | input | 1 | Software load; sets the valid bit at the pointer |
| itlb_fill_i | input | 1 | Instruction-buffer fill strobe |
| itlb_idx_i | input | 2 | Instruction-buffer entry being filled |
| sq_access_i | input | 1 | Store-queue access in progress |
| user_i | input | 1 | 1 for a user-mode access |
| repl_idx_o | output | 6 | Current replacement pointer |
| utlb_valid_o | output | 64 | Unified-buffer valid bits |
| itlb_valid_o | output | 4 | Instruction-buffer valid bits |
| sq_err_o | output | 1 | Store-queue address-error flag |
| single_vm_o | output | 1 | Mode bit |
| mode_warn_o | output | 1 | Sticky mode-change-without-invalidate warning |

## Verification
The bench drives the pointer onto a nonzero boundary and checks that it returns to zero. A design that wraps only at its natural modulus would read 5 there. It also loads the pointer above the boundary and watches it climb to 6'h3F and wrap. A design that compares with greater-or-equal would clear it at once. The bench hits the same-cycle cases as well: a write against an access, a load against an access, and an invalidate against a fill. A design that got the priority wrong would leave a stale pointer or a valid bit behind. Finally it writes all ones to catch reserved bits that were stored or a command bit that reads back, and it flips the mode bit with and without invalidate to check the sticky warning.

// File: rtl/tlb_ctrl_pkg.sv
package tlb_ctrl_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned BND_LSB = 18;
  localparam int unsigned CNT_LSB = 10;
  localparam int unsigned SQ_BIT  = 9;
  localparam int unsigned VM_BIT  = 8;
  localparam int unsigned INV_BIT = 2;

  typedef struct packed {
    logic [IDX_W-1:0] bound;
    logic [IDX_W-1:0] cnt;
    logic             sq_priv;
    logic             single_vm;
    logic             inval;
  } ctrl_wr_t;

  function automatic ctrl_wr_t decode_wr(input logic [REG_W-1:0] d);
    ctrl_wr_t f;
    f.bound     = d[BND_LSB +: IDX_W];
    f.cnt       = d[CNT_LSB +: IDX_W];
    f.sq_priv   = d[SQ_BIT];
    f.single_vm = d[VM_BIT];
    f.inval     = d[INV_BIT];
    return f;
  endfunction
endpackage

// File: rtl/tlb_repl_counter.sv
module tlb_repl_counter #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_val_i,
  input  logic [IDX_W-1:0] bound_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] cnt_o
);
  localparam logic [IDX_W-1:0] ZERO = '0;

  logic [IDX_W-1:0] cnt_q;
  logic             at_bound;

  // a zero boundary disables the early wrap; natural overflow handles 3F->0
  assign at_bound = (bound_i != ZERO) && (cnt_q == bound_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_i)     cnt_q <= wr_val_i;
    else if (step_i)   cnt_q <= at_bound ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !step_i) |=> (cnt_o == $past(cnt_o)));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && step_i && bound_i != ZERO && cnt_o == bound_i) |=> (cnt_o == ZERO));
  p_past_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && step_i && cnt_o > bound_i && cnt_o != '1) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_write_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wr_val_i)));
endmodule

// File: rtl/tlb_valid_array.sv
module tlb_valid_array #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0] valid_q;

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      valid_q[g] <= 1'b0;
      else if (clr_i)                                   valid_q[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g))         valid_q[g] <= 1'b1;
    end
  end

  assign valid_o = valid_q;

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (valid_o == '0));
  p_single_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i) |=> ($countones(valid_o & ~$past(valid_o)) <= 1));
endmodule

// File: rtl/tlb_sq_guard.sv
module tlb_sq_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sq_priv_i,
  input  logic sq_access_i,
  input  logic user_i,
  output logic err_o
);
  assign err_o = sq_priv_i & sq_access_i & user_i;

  p_err_user_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (user_i && sq_access_i));
endmodule

// File: rtl/tlb_ctrl_reg.sv
module tlb_ctrl_reg
  import tlb_ctrl_pkg::*;
#(
  parameter int unsigned UTLB_N = 64,
  parameter int unsigned ITLB_N = 4,
  localparam int unsigned ITLB_IW = (ITLB_N > 1) ? $clog2(ITLB_N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic                 tlb_access_i,
  input  logic                 tlb_load_i,
  input  logic                 itlb_fill_i,
  input  logic [ITLB_IW-1:0]   itlb_idx_i,
  input  logic                 sq_access_i,
  input  logic                 user_i,
  output logic [IDX_W-1:0]     repl_idx_o,
  output logic [UTLB_N-1:0]    utlb_valid_o,
  output logic [ITLB_N-1:0]    itlb_valid_o,
  output logic                 sq_err_o,
  output logic                 single_vm_o,
  output logic                 mode_warn_o
);
  ctrl_wr_t         wf;
  logic [IDX_W-1:0] bound_q;
  logic             sq_priv_q;
  logic             vm_q;
  logic             warn_q;
  logic             inval;

  assign wf    = decode_wr(reg_wdata_i);
  assign inval = reg_we_i & wf.inval;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bound_q   <= '0;
      sq_priv_q <= 1'b0;
      vm_q      <= 1'b0;
      warn_q    <= 1'b0;
    end else if (reg_we_i) begin
      bound_q   <= wf.bound;
      sq_priv_q <= wf.sq_priv;
      vm_q      <= wf.single_vm;
      if (wf.single_vm != vm_q && !wf.inval) warn_q <= 1'b1;
    end
  end

  tlb_repl_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_we_i),
    .wr_val_i (wf.cnt),
    .bound_i  (bound_q),
    .step_i   (tlb_access_i),
    .cnt_o    (repl_idx_o)
  );

  tlb_valid_array #(.N(UTLB_N), .IDX_W(IDX_W)) u_utlb_v (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (inval),
    .set_i     (tlb_load_i),
    .set_idx_i (repl_idx_o),
    .valid_o   (utlb_valid_o)
  );

  tlb_valid_array #(.N(ITLB_N), .IDX_W(ITLB_IW)) u_itlb_v (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (inval),
    .set_i     (itlb_fill_i),
    .set_idx_i (itlb_idx_i),
    .valid_o   (itlb_valid_o)
  );

  tlb_sq_guard u_sq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sq_priv_i   (sq_priv_q),
    .sq_access_i (sq_access_i),
    .user_i      (user_i),
    .err_o       (sq_err_o)
  );

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[BND_LSB +: IDX_W]     = bound_q;
    reg_rdata_o[CNT_LSB +: IDX_W]     = repl_idx_o;
    reg_rdata_o[SQ_BIT]               = sq_priv_q;
    reg_rdata_o[VM_BIT]               = vm_q;
  end

  assign single_vm_o = vm_q;
  assign mode_warn_o = warn_q;

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31:24] == '0) && (reg_rdata_o[17:16] == '0) && (reg_rdata_o[7:2] == '0));
  p_warn_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_warn_o |=> mode_warn_o);
  p_warn_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_warn_o) |-> $past(reg_we_i && !reg_wdata_i[INV_BIT]));
endmodule

// File: tb/tlb_ctrl_reg_test.sv
module tlb_ctrl_reg_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 16;

  // {we, wdata[31:0], access, load, expected pointer[5:0]}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd1},   // R3
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd2},   // R3
    {1'b0, 32'h0000_0000, 1'b0, 1'b1, 6'd2},   // R6 load holds
    {1'b1, 32'h0010_0800, 1'b0, 1'b0, 6'd2},   // bound 4, ptr 2
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd3},
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd4},
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd0},   // R4 wrap at bound
    {1'b1, 32'h0010_2800, 1'b0, 1'b0, 6'd10},  // ptr above bound
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd11},  // R5
    {1'b1, 32'h0010_F800, 1'b0, 1'b0, 6'd62},
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd63},  // R5
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd0},   // R5 wrap after 3F
    {1'b1, 32'h0010_1C00, 1'b1, 1'b0, 6'd7},   // R7 write beats access
    {1'b0, 32'h0000_0000, 1'b1, 1'b1, 6'd8},   // R6 load at 7
    {1'b1, 32'h0000_FC00, 1'b0, 1'b0, 6'd63},  // bound 0
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 6'd0}    // R4 natural wrap
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tlb_access_i = 1'b0;
  logic        tlb_load_i = 1'b0;
  logic        itlb_fill_i = 1'b0;
  logic [1:0]  itlb_idx_i = '0;
  logic        sq_access_i = 1'b0;
  logic        user_i = 1'b0;
  logic [5:0]  repl_idx_o;
  logic [63:0] utlb_valid_o;
  logic [3:0]  itlb_valid_o;
  logic        sq_err_o;
  logic        single_vm_o;
  logic        mode_warn_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlb_ctrl_reg uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [31:0] wd, input bit acc, input bit ld);
    @(negedge clk_i);
    reg_we_i = we; reg_wdata_i = wd; tlb_access_i = acc; tlb_load_i = ld;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0; tlb_access_i = 1'b0; tlb_load_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(reg_rdata_o == 32'h0, "R1 rdata", 64'(reg_rdata_o), 64'h0);
    chk(utlb_valid_o == '0 && itlb_valid_o == '0, "R1 valid", 64'(utlb_valid_o), 64'h0);
    chk(mode_warn_o == 1'b0, "R1 warn", 64'(mode_warn_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][40], VEC[i][39:8], VEC[i][7], VEC[i][6]);
      chk(repl_idx_o == VEC[i][5:0], $sformatf("R3/R4/R5/R6/R7 vec %0d", i),
          64'(repl_idx_o), 64'(VEC[i][5:0]));
      chk(reg_rdata_o[15:10] == VEC[i][5:0], "R2 ptr field", 64'(reg_rdata_o[15:10]), 64'(VEC[i][5:0]));
    end
    // R6 loads at pointer 2 and 7
    chk(utlb_valid_o == 64'h84, "R6 valid set", utlb_valid_o, 64'h84);

    // R12 instruction fill
    @(negedge clk_i); itlb_fill_i = 1'b1; itlb_idx_i = 2'd2;
    @(negedge clk_i); itlb_fill_i = 1'b0;
    chk(itlb_valid_o == 4'b0100, "R12 itlb fill", 64'(itlb_valid_o), 64'h4);

    // R8 invalidate beats same-cycle fills
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = 32'h4; tlb_load_i = 1'b1; itlb_fill_i = 1'b1; itlb_idx_i = 2'd1;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0; tlb_load_i = 1'b0; itlb_fill_i = 1'b0;
    chk(utlb_valid_o == '0, "R8 utlb clear", utlb_valid_o, 64'h0);
    chk(itlb_valid_o == '0, "R8 itlb clear", 64'(itlb_valid_o), 64'h0);
    chk(reg_rdata_o[2] == 1'b0, "R2 inval reads 0", 64'(reg_rdata_o[2]), 64'h0);

    // R2 all-ones write, mode change with invalidate
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk(reg_rdata_o == 32'h00FC_FF00, "R2 readback", 64'(reg_rdata_o), 64'h00FCFF00);
    chk(single_vm_o == 1'b1, "R10 single vm", 64'(single_vm_o), 64'h1);
    chk(mode_warn_o == 1'b0, "R11 no warn with inval", 64'(mode_warn_o), 64'h0);

    // R9 store-queue privilege
    sq_access_i = 1'b1; user_i = 1'b1; #1;
    chk(sq_err_o == 1'b1, "R9 user err", 64'(sq_err_o), 64'h1);
    user_i = 1'b0; #1;
    chk(sq_err_o == 1'b0, "R9 priv ok", 64'(sq_err_o), 64'h0);
    sq_access_i = 1'b0;

    // R11 mode flip without invalidate
    cyc(1'b1, 32'h0000_0000, 1'b0, 1'b0);
    chk(mode_warn_o == 1'b1, "R11 warn set", 64'(mode_warn_o), 64'h1);
    chk(single_vm_o == 1'b0, "R10 multi vm", 64'(single_vm_o), 64'h0);
    sq_access_i = 1'b1; user_i = 1'b1; #1;
    chk(sq_err_o == 1'b0, "R9 open access", 64'(sq_err_o), 64'h0);
    sq_access_i = 1'b0; user_i = 1'b0;
    cyc(1'b1, 32'h0000_0004, 1'b0, 1'b0);
    chk(mode_warn_o == 1'b1, "R11 sticky", 64'(mode_warn_o), 64'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule